// File: doc/BRIEF.md
# Three-Wire Serial Access Port for a BCD Real-Time Clock

This block is the device side of a three-wire serial port into a real-time clock, together with a simplified BCD time-of-day and calendar counter chain. A host selects the port with a chip-enable line and picks the direction with a write-select line. It then toggles a serial clock and moves one 52-bit frame across a data line that is split into input, output and output-enable. The time counters advance from a fast enable tick through a sub-second prescaler. The seconds, minutes, hours, weekday, day, month and year fields are stored in BCD and carry into one another.

A read takes a parallel snapshot of every counter on its first serial clock and shifts it out least significant bit first. Because the frame comes from the snapshot, a carry during the transfer cannot tear it. A write collects 52 bits and commits them to the counters only when the frame is complete. From the first serial clock of a write until chip-enable drops, the prescaler is held at zero, so the first second after a write counts from the moment the port is released. All port inputs are sampled by the system clock, so the serial clock must stay in each level for at least two system clock cycles. The reset is asynchronous active-low and is released through a two-stage synchronizer.

Top module: `rtc_serial_top`

## Requirements
- R1: data_oe is 1 only while ce is 1 and wr is 0 (read direction); with ce at 0, or in the write direction, it is 0.
- R2: In the read direction, the first rising sclk edge after ce rises latches every counter and the flag into the frame, and data_o then shows frame bit 0, the seconds LSB.
- R3: Frame bit positions, sent and received LSB first: seconds [7:0], minutes [15:8], hours [23:16], weekday [27:24], day of month [35:28], month [43:36], year [51:44]. Every field is in BCD. Each later rising sclk edge moves data_o to the next bit.
- R4: From the 52nd rising edge of a read on, data_o holds frame bit 51 for any further sclk edges while ce stays 1.
- R5: Dropping ce ends a read early, after any number of bits. The next read starts again at bit 0 with a new snapshot.
- R6: In the write direction, data_i is sampled on each rising sclk edge into the frame, in the R3 layout. On the 52nd edge the counters load the frame. Bit 7 of the seconds byte is ignored and stored as 0.
- R7: Write bits after the 52nd have no effect on the counters.
- R8: If ce falls before 52 write bits have arrived, the counters keep their previous contents.
- R9: After the first falling sclk edge of a write, the sub-second prescaler is cleared and no seconds carry occurs until ce falls. After ce falls, exactly TICKS_PER_SEC tick_en pulses produce the next seconds step.
- R10: Frame bit 7 reads 1 after reset until the first completed write, and 0 from then on.
- R11: Seconds and minutes wrap 59 to 00, hours 23 to 00, weekday 7 to 1, month 12 to 01 and year 99 to 00. Each wrap carries into the next field, and the day carry advances both the weekday and the day of month.
- R12: The day of month wraps to 01 after 28 in month 02, after 30 in months 04, 06, 09 and 11, and after 31 in all other months. There is no leap-year adjustment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescaler enable, one pulse per sub-second tick |
| ce | input | 1 | Port select, active high |
| wr | input | 1 | Direction select: 1 write, 0 read |
| sclk | input | 1 | Serial clock from the host |
| data_i | input | 1 | Serial data into the device |
| data_o | output | 1 | Serial data out of the device |
| data_oe | output | 1 | Drive enable for data_o |

## Verification
An internal fault shows up as a wrong bit in a read frame. A bad bit counter or shift path misplaces bits within one serial clock period. A wrong commit or abort decision appears in the next full read as a stale or partly changed time. A carry-chain or month-table fault is seen only after the single tick that crosses the boundary, so each wrap is set up by a write, one tick short of the edge. The prescaler hold is checked by counting the ticks between ce falling and the first seconds step. A leak during the hold shows up as an early step.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int FRAME_BITS = 52;

  // Packed so that bit 0 is the seconds LSB, matching the serial order.
  typedef struct packed {
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] day;
    logic [3:0] dow;
    logic [7:0] hour;
    logic [7:0] minute;
    logic [7:0] sec;
  } rtc_time_t;

  // Two-digit BCD increment. Returns {wrapped, next value}.
  function automatic logic [8:0] bcd_step(input logic [7:0] v,
                                          input logic [7:0] top,
                                          input logic [7:0] base);
    logic [8:0] r;
    if (v == top)
      r = {1'b1, base};
    else if (v[3:0] == 4'd9)
      r = {1'b0, v[7:4] + 4'd1, 4'd0};
    else
      r = {1'b0, v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Last day of a BCD month, no leap years.
  function automatic logic [7:0] month_last_day(input logic [7:0] m);
    logic [7:0] r;
    case (m)
      8'h02:                      r = 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rtc_time_counters.sv
module rtc_time_counters
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_en,
  input  logic      hold_presc,
  input  logic      load_en,
  input  rtc_time_t load_val,
  output rtc_time_t cur,
  output logic      time_unset
);
  localparam int PW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PW-1:0] PLAST = PW'(TICKS_PER_SEC - 1);

  logic [PW-1:0] presc_q, presc_d;
  logic          presc_en;
  rtc_time_t     time_q, time_d;
  logic          time_en;
  logic          unset_q;
  logic          sec_carry;

  logic [8:0] s_n, m_n, h_n, d_n, mo_n, y_n;
  logic [7:0] day_top;
  logic [3:0] dow_n;

  // Candidate next value of every field.
  always_comb begin
    s_n     = bcd_step(time_q.sec,    8'h59, 8'h00);
    m_n     = bcd_step(time_q.minute, 8'h59, 8'h00);
    h_n     = bcd_step(time_q.hour,   8'h23, 8'h00);
    day_top = month_last_day(time_q.month);
    d_n     = bcd_step(time_q.day,    day_top, 8'h01);
    mo_n    = bcd_step(time_q.month,  8'h12, 8'h01);
    y_n     = bcd_step(time_q.year,   8'h99, 8'h00);
    dow_n   = (time_q.dow == 4'd7) ? 4'd1 : time_q.dow + 4'd1;
  end

  // Prescaler: held at zero while a write has the carry blocked.
  always_comb begin
    presc_d   = presc_q;
    sec_carry = 1'b0;
    if (hold_presc) begin
      presc_d = '0;
    end else if (tick_en) begin
      if (presc_q == PLAST) begin
        presc_d   = '0;
        sec_carry = 1'b1;
      end else begin
        presc_d = presc_q + 1'b1;
      end
    end
  end
  assign presc_en = hold_presc | tick_en;

  // Carry chain; a committed frame takes priority over a carry.
  always_comb begin
    time_d = time_q;
    if (load_en) begin
      time_d        = load_val;
      time_d.sec[7] = 1'b0;
    end else if (sec_carry) begin
      time_d.sec = s_n[7:0];
      if (s_n[8]) begin
        time_d.minute = m_n[7:0];
        if (m_n[8]) begin
          time_d.hour = h_n[7:0];
          if (h_n[8]) begin
            time_d.dow = dow_n;
            time_d.day = d_n[7:0];
            if (d_n[8]) begin
              time_d.month = mo_n[7:0];
              if (mo_n[8])
                time_d.year = y_n[7:0];
            end
          end
        end
      end
    end
  end
  assign time_en = load_en | sec_carry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      time_q  <= '{year: 8'h00, month: 8'h01, day: 8'h01, dow: 4'd1,
                   hour: 8'h00, minute: 8'h00, sec: 8'h00};
      unset_q <= 1'b1;
    end else begin
      if (presc_en) presc_q <= presc_d;
      if (time_en)  time_q  <= time_d;
      if (load_en)  unset_q <= 1'b0;
    end
  end

  assign cur        = time_q;
  assign time_unset = unset_q;
endmodule

// File: rtl/rtc_serial_port.sv
module rtc_serial_port
  import rtc_pkg::*;
#(
  parameter int FB = FRAME_BITS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ce,
  input  logic                          wr,
  input  logic                          sclk,
  input  logic                          sdin,
  input  logic [FB-1:0]                 snap,
  output logic                          sdout,
  output logic                          sdoe,
  output logic                          commit,
  output logic [FB-1:0]                 commit_word,
  output logic                          hold,
  output logic [$clog2(FB+1)-1:0]       bit_cnt
);
  localparam int CW = $clog2(FB + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(FB);
  localparam logic [CW-1:0] CNT_LAST = CW'(FB - 1);

  logic          sclk_q;
  logic          sclk_rise, sclk_fall;
  logic          rd_mode, wr_mode;
  logic [FB-1:0] sh_q, sh_d;
  logic          sh_en;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          hold_q, hold_d;

  assign sclk_rise = sclk & ~sclk_q;
  assign sclk_fall = ~sclk & sclk_q;
  assign rd_mode   = ce & ~wr;
  assign wr_mode   = ce & wr;

  always_comb begin
    sh_d   = sh_q;
    sh_en  = 1'b0;
    cnt_d  = cnt_q;
    hold_d = hold_q;
    commit = 1'b0;
    if (!ce) begin
      cnt_d  = '0;
      hold_d = 1'b0;
    end else begin
      if (sclk_rise && cnt_q != CNT_FULL) begin
        cnt_d = cnt_q + 1'b1;
        sh_en = 1'b1;
        if (rd_mode) begin
          sh_d = (cnt_q == '0) ? snap : {1'b0, sh_q[FB-1:1]};
        end else begin
          sh_d = {sdin, sh_q[FB-1:1]};
          if (cnt_q == CNT_LAST) commit = 1'b1;
        end
      end
      if (wr_mode && sclk_fall && cnt_q == CW'(1))
        hold_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sh_q   <= '0;
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      sclk_q <= sclk;
      if (sh_en) sh_q <= sh_d;
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
    end
  end

  assign commit_word = {sdin, sh_q[FB-1:1]};
  assign sdout       = sh_q[0];
  assign sdoe        = rd_mode;
  assign hold        = hold_q;
  assign bit_cnt     = cnt_q;
endmodule

// File: rtl/rtc_serial_top.sv
module rtc_serial_top
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic ce,
  input  logic wr,
  input  logic sclk,
  input  logic data_i,
  output logic data_o,
  output logic data_oe
);
  localparam int CW = $clog2(FRAME_BITS + 1);

  logic [1:0]            rst_sync;
  logic                  rst_n_int;
  rtc_time_t             cur_time;
  logic                  time_unset;
  logic [FRAME_BITS-1:0] snap;
  logic                  commit;
  logic [FRAME_BITS-1:0] commit_word;
  logic                  hold;
  logic [CW-1:0]         bit_cnt;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  assign snap = {cur_time[FRAME_BITS-1:8], time_unset, cur_time[6:0]};

  rtc_serial_port #(.FB(FRAME_BITS)) u_port (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .ce          (ce),
    .wr          (wr),
    .sclk        (sclk),
    .sdin        (data_i),
    .snap        (snap),
    .sdout       (data_o),
    .sdoe        (data_oe),
    .commit      (commit),
    .commit_word (commit_word),
    .hold        (hold),
    .bit_cnt     (bit_cnt)
  );

  rtc_time_counters #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .tick_en    (tick_en),
    .hold_presc (hold),
    .load_en    (commit),
    .load_val   (rtc_time_t'(commit_word)),
    .cur        (cur_time),
    .time_unset (time_unset)
  );
endmodule

// File: rtl/rtc_serial_checker.sv
module rtc_serial_checker #(
  parameter int FB = 52
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ce,
  input logic                    data_o,
  input logic                    data_oe,
  input logic [$clog2(FB+1)-1:0] bit_cnt,
  input logic                    commit,
  input logic [FB-1:0]           commit_word,
  input logic                    hold,
  input logic [FB-1:0]           cur
);
  localparam logic [FB-1:0] SEC_FLAG_MASK = ~(FB'(1) << 7);

  // R4: once the frame is exhausted the read output is frozen
  assert_out_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && $past(data_oe) && bit_cnt == FB && $past(bit_cnt) == FB)
      |-> $stable(data_o));

  // R6: a commit loads the counters on the next cycle, seconds bit 7 cleared
  assert_commit_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (cur == ($past(commit_word) & SEC_FLAG_MASK)));

  // R8: a commit only ever closes a full frame
  assert_commit_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (bit_cnt == FB));

  // R9: while the carry is blocked the seconds do not move except by a commit
  assert_sec_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hold) && !$past(commit)) |-> $stable(cur[7:0]));

  // R9: dropping ce releases the block
  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> !hold);

  // R11: seconds and hours stay legal BCD
  assert_bcd_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cur[3:0] <= 4'd9) && (cur[7:4] <= 4'd5) && (cur[23:16] <= 8'h23));
endmodule

bind rtc_serial_top rtc_serial_checker #(.FB(rtc_pkg::FRAME_BITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_int),
  .ce          (ce),
  .data_o      (data_o),
  .data_oe     (data_oe),
  .bit_cnt     (bit_cnt),
  .commit      (commit),
  .commit_word (commit_word),
  .hold        (hold),
  .cur         (cur_time)
);

// File: tb/rtc_serial_top_tb.sv
module rtc_serial_top_tb;
  localparam int TPS = 4;
  localparam int HP  = 4;

  logic clk, rst_n, tick_en, ce, wr, sclk, data_i;
  logic data_o, data_oe;

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct {
    logic  v;
    string tag;
  } exp_t;
  exp_t sb_q[$];
  event sample_ev;

  rtc_serial_top #(.TICKS_PER_SEC(TPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ce(ce), .wr(wr),
    .sclk(sclk), .data_i(data_i), .data_o(data_o), .data_oe(data_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // Scoreboard monitor: pops one expected bit per sample event.
  initial begin
    forever begin
      @(sample_ev);
      if (sb_q.size() == 0) begin
        check(64'd1, 64'd0, "scoreboard-empty");
      end else begin
        exp_t it;
        it = sb_q.pop_front();
        check({63'd0, data_o}, {63'd0, it.v}, it.tag);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  function automatic logic [51:0] tw(input logic [7:0] y, input logic [7:0] mo,
                                     input logic [7:0] d, input logic [3:0] dw,
                                     input logic [7:0] h, input logic [7:0] mi,
                                     input logic [7:0] s, input logic fl);
    return {y, mo, d, dw, h, mi, fl, s[6:0]};
  endfunction

  task automatic half();
    repeat (HP) @(negedge clk);
  endtask

  task automatic tick_n(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  // Driver: pushes the expected bit for each edge, then raises sclk.
  task automatic read_frame(input logic [51:0] w, input int nbits, input string tag);
    ce = 1'b1; wr = 1'b0; half();
    check({63'd0, data_oe}, 64'd1, "R1 oe in read");
    for (int i = 0; i < nbits; i++) begin
      exp_t it;
      it.v   = (i < 52) ? w[i] : w[51];
      it.tag = (i >= 52) ? "R4" : (i == 0) ? "R2" : (i == 7) ? "R10" : tag;
      sb_q.push_back(it);
      sclk = 1'b1; half();
      ->sample_ev;
      sclk = 1'b0; half();
    end
    ce = 1'b0; half();
    check({63'd0, data_oe}, 64'd0, "R1 oe idle");
  endtask

  task automatic write_frame(input logic [51:0] w, input int nbits,
                             input int mid_ticks, input int end_ticks);
    ce = 1'b1; wr = 1'b1; half();
    check({63'd0, data_oe}, 64'd0, "R1 oe in write");
    for (int i = 0; i < nbits; i++) begin
      data_i = (i < 52) ? w[i] : 1'b1;
      half();
      sclk = 1'b1; half();
      sclk = 1'b0; half();
      if (i == 0) tick_n(mid_ticks);
    end
    tick_n(end_ticks);
    ce = 1'b0; wr = 1'b0; data_i = 1'b0; half();
  endtask

  initial begin
    logic [51:0] t1, t2;
    rst_n = 1'b0; tick_en = 1'b0; ce = 1'b0; wr = 1'b0; sclk = 1'b0; data_i = 1'b0;
    repeat (3) @(negedge clk);
    check({63'd0, data_oe}, 64'd0, "R1 oe in reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // Reset contents with the unset flag (R3, R10)
    read_frame(tw(8'h00, 8'h01, 8'h01, 4'd1, 8'h00, 8'h00, 8'h00, 1'b1), 52, "R3");

    // Full write with seconds bit 7 set; read back 56 bits (R6, R4, R10)
    t1 = tw(8'h24, 8'h07, 8'h15, 4'd3, 8'h13, 8'h45, 8'h27, 1'b1);
    write_frame(t1, 52, 0, 0);
    t1 = tw(8'h24, 8'h07, 8'h15, 4'd3, 8'h13, 8'h45, 8'h27, 1'b0);
    read_frame(t1, 56, "R6");

    // Early end of a read, then a fresh snapshot (R5)
    read_frame(t1, 28, "R5");
    tick_n(TPS);
    t1 = tw(8'h24, 8'h07, 8'h15, 4'd3, 8'h13, 8'h45, 8'h28, 1'b0);
    read_frame(t1, 52, "R5");

    // Short write commits nothing (R8)
    write_frame(tw(8'h55, 8'h05, 8'h05, 4'd5, 8'h05, 8'h05, 8'h05, 1'b0), 30, 0, 0);
    read_frame(t1, 52, "R8");

    // Over-long write: extra ones ignored (R7)
    t2 = tw(8'h99, 8'h12, 8'h31, 4'd7, 8'h23, 8'h59, 8'h59, 1'b0);
    write_frame(t2, 60, 0, 0);
    read_frame(t2, 52, "R7");

    // One tick short, then the full rollover (R11)
    tick_n(TPS - 1);
    read_frame(t2, 52, "R11");
    tick_n(1);
    read_frame(tw(8'h00, 8'h01, 8'h01, 4'd1, 8'h00, 8'h00, 8'h00, 1'b0), 52, "R11");

    // Hour carry without a day carry (R11)
    write_frame(tw(8'h05, 8'h03, 8'h09, 4'd4, 8'h10, 8'h59, 8'h59, 1'b0), 52, 0, 0);
    tick_n(TPS);
    read_frame(tw(8'h05, 8'h03, 8'h09, 4'd4, 8'h11, 8'h00, 8'h00, 1'b0), 52, "R11");

    // Month lengths (R12)
    write_frame(tw(8'h23, 8'h02, 8'h28, 4'd2, 8'h23, 8'h59, 8'h59, 1'b0), 52, 0, 0);
    tick_n(TPS);
    read_frame(tw(8'h23, 8'h03, 8'h01, 4'd3, 8'h00, 8'h00, 8'h00, 1'b0), 52, "R12");
    write_frame(tw(8'h23, 8'h04, 8'h30, 4'd6, 8'h23, 8'h59, 8'h59, 1'b0), 52, 0, 0);
    tick_n(TPS);
    read_frame(tw(8'h23, 8'h05, 8'h01, 4'd7, 8'h00, 8'h00, 8'h00, 1'b0), 52, "R12");
    write_frame(tw(8'h23, 8'h05, 8'h30, 4'd1, 8'h23, 8'h59, 8'h59, 1'b0), 52, 0, 0);
    tick_n(TPS);
    read_frame(tw(8'h23, 8'h05, 8'h31, 4'd2, 8'h00, 8'h00, 8'h00, 1'b0), 52, "R12");

    // Prescaler clear and carry block during a write (R9)
    tick_n(2);
    t1 = tw(8'h30, 8'h06, 8'h10, 4'd2, 8'h08, 8'h20, 8'h10, 1'b0);
    write_frame(t1, 52, 10, 10);
    read_frame(t1, 52, "R9");
    tick_n(TPS - 1);
    read_frame(t1, 52, "R9");
    tick_n(1);
    read_frame(tw(8'h30, 8'h06, 8'h10, 4'd2, 8'h08, 8'h20, 8'h11, 1'b0), 52, "R9");

    check({63'd0, data_oe}, 64'd0, "R1 oe at end");
    check(64'(sb_q.size()), 64'd0, "R3 scoreboard drained");
    finish_run();
  end
endmodule